// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers thirteen peripheral interrupt sources into one vectored request for a CPU sequencer. Each source has a sticky flag and an individual enable. One global enable gates all of them. When several sources are pending and enabled, the one with the lowest vector number wins. The winning vector number is presented with the request and is held steady until the sequencer acknowledges it. The acknowledge clears the winning flag in hardware. Software clears flags by writing ones into two byte-wide flag locations.

The block also follows the entry and return handshake around the handler. Accepting a request clears the global enable and runs a four-cycle entry phase, which moves a modelled stack pointer down by two. A return strobe runs a four-cycle return phase, which moves the stack pointer up by two and sets the global enable again. After a return, no new request is raised until the CPU reports that one instruction has retired. No new request is raised while a multi-cycle instruction is in progress.

The two external sources can be switched to level mode. In level mode the source has no flag and asks for service only while its active-low pin is held low. The CPU pipeline lies outside the block: the instruction-retire, busy-instruction and return strobes arrive as inputs.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `flags` is 0, `gie` is 0, `irq_req` is 0, `irq_vec` is 0, `seq_busy` is 0 and `stk_ptr` is 0xDF.
- R2: A high `src_set[i]` sets `flags[i]` at the next edge. Source i uses vector number i+1. The flag stays set, whatever its enable or the global enable, until it is cleared.
- R3: A flag write with `flag_addr`=a and `flag_wdata` bit b clears flag 8a+b when that bit is 1. A bit written as 0 has no effect. A `src_set` pulse in the same cycle wins over the clear.
- R4: `irq_req` rises one cycle after a source is pending, is enabled and has `gie` set, with the sequencer idle and no hold. `irq_vec` is then the lowest pending enabled index plus one, so vector 1 (external 0) has the highest priority.
- R5: While `irq_req` is high, `irq_vec` does not change until the acknowledge, even if a higher-priority source becomes pending.
- R6: `irq_ack` taken while `irq_req` is high drops `irq_req`, clears `gie` and clears the winning flag at the next edge. `seq_busy` is then high for 4 cycles, after which `stk_ptr` has dropped by 2.
- R7: When `lvl_mode[k]` is 1 (k = 0 or 1), `flags[k]` is held at 0. Source k is pending while `lvl_pin_n[k]` is 0, and the acknowledge clears nothing for it.
- R8: A `ret_strobe` while idle makes `seq_busy` high for 4 cycles, after which `gie` is 1 and `stk_ptr` has risen by 2.
- R9: After a return phase ends, no request is raised until one `insn_retire` strobe has been seen.
- R10: No new request is raised while `insn_busy` is high. The request is raised once it falls.
- R11: A `gie_wr` while idle and not acknowledging loads `gie` from `gie_wdata`. Clearing `gie` withdraws a pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_set | input | 13 | Per-source event strobes, index i = vector i+1 |
| lvl_mode | input | 2 | Level mode select for external sources 0 and 1 |
| lvl_pin_n | input | 2 | Active-low external pins used in level mode |
| src_en | input | 13 | Per-source enables |
| flag_wr | input | 1 | Flag write strobe (write-one-to-clear) |
| flag_addr | input | 1 | Flag byte select |
| flag_wdata | input | 8 | Flag write data |
| gie_wr | input | 1 | Global enable write strobe |
| gie_wdata | input | 1 | Global enable write value |
| insn_busy | input | 1 | Multi-cycle instruction in progress |
| insn_retire | input | 1 | One main-program instruction retired |
| irq_ack | input | 1 | Sequencer accepts the current request |
| ret_strobe | input | 1 | Return-from-interrupt issued |
| irq_req | output | 1 | Interrupt request |
| irq_vec | output | 4 | Vector number of the request |
| flags | output | 13 | Latched source flags |
| gie | output | 1 | Global enable |
| seq_busy | output | 1 | Entry or return phase in progress |
| stk_ptr | output | 8 | Modelled stack pointer |

## Verification
The assertions assume that the sequencer raises `irq_ack` only while `irq_req` is high. They also assume that `ret_strobe` comes only while the sequencer is idle and never in the same cycle as an acknowledge. The bench drives every strobe for exactly one cycle at the falling edge. It issues an acknowledge only after it has seen the request, and a return only after the entry phase has finished. Flag writes and `src_set` pulses may overlap, because the block resolves that case itself.

// File: rtl/irq_vector_pkg.sv
// Shared types for the vectored interrupt controller.
// Assumes: nothing beyond IEEE 1800-2017.
package irq_vector_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_ENTRY  = 2'd1,
        SEQ_RETURN = 2'd2
    } seq_state_e;
endpackage

// File: rtl/irq_flag_bank.sv
// Sticky per-source flags with write-one-to-clear byte access, hardware
// clear on acknowledge, and level-mode handling for the low sources.
// Assumes: hw_clr is at most one-hot; set has priority over any clear.
module irq_flag_bank #(
    parameter int NUM_SRC = 13,
    parameter int NUM_LVL = 2,
    parameter int ADDR_W  = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_set,
    input  logic [NUM_LVL-1:0] lvl_mode,
    input  logic [NUM_LVL-1:0] lvl_pin_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [7:0]         wr_data,
    input  logic [NUM_SRC-1:0] hw_clr,
    output logic [NUM_SRC-1:0] flag_q,
    output logic [NUM_SRC-1:0] pending
);
    logic [NUM_SRC-1:0] clr_w;

    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_src
        localparam int BYTE_IDX = gi / 8;
        localparam int BIT_IDX  = gi % 8;

        // decode the software clear for this bit
        assign clr_w[gi] = wr_en && (wr_addr == ADDR_W'(BYTE_IDX)) && wr_data[BIT_IDX];

        if (gi < NUM_LVL) begin : g_lvl
            // flag update; level mode forces the flag low
            always_ff @(posedge clk) begin
                if (!rst_n)                        flag_q[gi] <= 1'b0;
                else if (lvl_mode[gi])             flag_q[gi] <= 1'b0;
                else if (src_set[gi])              flag_q[gi] <= 1'b1;
                else if (clr_w[gi] || hw_clr[gi])  flag_q[gi] <= 1'b0;
            end
            assign pending[gi] = lvl_mode[gi] ? ~lvl_pin_n[gi] : flag_q[gi];

            assert_lvl_noflag_R7: assert property (@(posedge clk) disable iff (!rst_n)
                lvl_mode[gi] |=> !flag_q[gi]);
        end else begin : g_edge
            // flag update for an edge-only source
            always_ff @(posedge clk) begin
                if (!rst_n)                        flag_q[gi] <= 1'b0;
                else if (src_set[gi])              flag_q[gi] <= 1'b1;
                else if (clr_w[gi] || hw_clr[gi])  flag_q[gi] <= 1'b0;
            end
            assign pending[gi] = flag_q[gi];
        end

        assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_w[gi] && !src_set[gi]) |=> !flag_q[gi]);
        assert_set_sticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
            src_set[gi] && !(gi < NUM_LVL && lvl_mode[gi % NUM_LVL]) |=> flag_q[gi]);
    end
endmodule

// File: rtl/irq_prio_sel.sv
// Combinational lowest-index-first search over enabled pending sources.
// Assumes: vector number = source index + 1; 0 means no winner.
module irq_prio_sel #(
    parameter int NUM_SRC = 13,
    parameter int VEC_W   = 4
) (
    input  logic [NUM_SRC-1:0] masked,
    output logic [NUM_SRC-1:0] grant,
    output logic               any,
    output logic [VEC_W-1:0]   win_vec
);
    logic [NUM_SRC:0] seen;

    assign seen[0] = 1'b0;
    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_chain
        assign grant[gi]  = masked[gi] & ~seen[gi];
        assign seen[gi+1] = seen[gi] | masked[gi];
    end
    assign any = seen[NUM_SRC];

    // encode the one-hot grant into a vector number
    always_comb begin
        win_vec = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (grant[i]) win_vec = win_vec | VEC_W'(i + 1);
        end
    end
endmodule

// File: rtl/irq_entry_seq.sv
// Request latch, global enable, entry/return phases, stack pointer model
// and the one-instruction hold after return.
// Assumes: ret_strobe only while idle and never together with a taken ack.
module irq_entry_seq
    import irq_vector_pkg::*;
#(
    parameter int            VEC_W     = 4,
    parameter int            ENTRY_CYC = 4,
    parameter int            RET_CYC   = 4,
    parameter int            SP_W      = 8,
    parameter logic [SP_W-1:0] SP_INIT = 8'hDF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             any,
    input  logic [VEC_W-1:0] win_vec,
    input  logic             held_live,
    input  logic             insn_busy,
    input  logic             insn_retire,
    input  logic             irq_ack,
    input  logic             ret_strobe,
    input  logic             gie_wr,
    input  logic             gie_wdata,
    output logic             req_q,
    output logic [VEC_W-1:0] vec_q,
    output logic             gie_q,
    output logic             take,
    output logic             busy,
    output logic [SP_W-1:0]  sp_q
);
    localparam int MAX_CYC = (ENTRY_CYC > RET_CYC) ? ENTRY_CYC : RET_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC) + 1;

    seq_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic             hold_q;
    logic             idle;
    logic             eligible;
    logic             ret_end;

    assign idle     = (state == SEQ_IDLE);
    assign eligible = gie_q && !hold_q && !insn_busy && idle && any;
    assign take     = irq_ack && req_q && idle;
    assign ret_end  = (state == SEQ_RETURN) && (cnt == '0);
    assign busy     = !idle;

    // request latch: hold the vector until ack or withdrawal
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            vec_q <= '0;
        end else if (take) begin
            req_q <= 1'b0;
        end else if (req_q) begin
            if (!held_live || !gie_q || !idle) req_q <= 1'b0;
        end else if (eligible) begin
            req_q <= 1'b1;
            vec_q <= win_vec;
        end
    end

    // entry and return phase counter plus stack pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
            cnt   <= '0;
            sp_q  <= SP_INIT;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (take) begin
                        state <= SEQ_ENTRY;
                        cnt   <= CNT_W'(ENTRY_CYC - 1);
                    end else if (ret_strobe) begin
                        state <= SEQ_RETURN;
                        cnt   <= CNT_W'(RET_CYC - 1);
                    end
                end
                SEQ_ENTRY: begin
                    if (cnt == '0) begin
                        state <= SEQ_IDLE;
                        sp_q  <= sp_q - SP_W'(2);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                SEQ_RETURN: begin
                    if (cnt == '0) begin
                        state <= SEQ_IDLE;
                        sp_q  <= sp_q + SP_W'(2);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // global enable: ack clears, return end sets, software writes when idle
    always_ff @(posedge clk) begin
        if (!rst_n)              gie_q <= 1'b0;
        else if (take)           gie_q <= 1'b0;
        else if (ret_end)        gie_q <= 1'b1;
        else if (idle && gie_wr) gie_q <= gie_wdata;
    end

    // hold after return until one instruction retires
    always_ff @(posedge clk) begin
        if (!rst_n)                     hold_q <= 1'b0;
        else if (ret_end)               hold_q <= 1'b1;
        else if (idle && insn_retire)   hold_q <= 1'b0;
    end

    assert_req_only_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |-> idle);
    assert_vec_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && $past(req_q)) |-> (vec_q == $past(vec_q)));
    assert_take_clears_gie_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (!gie_q && !req_q && busy));
    assert_ret_sets_gie_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ret_end |=> (gie_q && idle));
    assert_hold_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q |-> !req_q);
    assert_busy_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_q && insn_busy) |=> !req_q);
endmodule

// File: rtl/irq_vector_ctrl.sv
// Top of the prioritized vectored interrupt controller: flags, priority
// search and entry/return sequencing.
// Assumes: irq_ack only while irq_req; ret_strobe only while idle.
module irq_vector_ctrl #(
    parameter int NUM_SRC   = 13,
    parameter int NUM_LVL   = 2,
    parameter int ENTRY_CYC = 4,
    parameter int RET_CYC   = 4,
    parameter int SP_W      = 8,
    parameter logic [SP_W-1:0] SP_INIT = 8'hDF,
    localparam int NBYTES   = (NUM_SRC + 7) / 8,
    localparam int ADDR_W   = (NBYTES > 1) ? $clog2(NBYTES) : 1,
    localparam int VEC_W    = $clog2(NUM_SRC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_set,
    input  logic [NUM_LVL-1:0] lvl_mode,
    input  logic [NUM_LVL-1:0] lvl_pin_n,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic               flag_wr,
    input  logic [ADDR_W-1:0]  flag_addr,
    input  logic [7:0]         flag_wdata,
    input  logic               gie_wr,
    input  logic               gie_wdata,
    input  logic               insn_busy,
    input  logic               insn_retire,
    input  logic               irq_ack,
    input  logic               ret_strobe,
    output logic               irq_req,
    output logic [VEC_W-1:0]   irq_vec,
    output logic [NUM_SRC-1:0] flags,
    output logic               gie,
    output logic               seq_busy,
    output logic [SP_W-1:0]    stk_ptr
);
    logic [NUM_SRC-1:0] pending;
    logic [NUM_SRC-1:0] masked;
    logic [NUM_SRC-1:0] grant;
    logic [NUM_SRC-1:0] hw_clr;
    logic [NUM_SRC-1:0] held_hit;
    logic               any;
    logic [VEC_W-1:0]   win_vec;
    logic               take;
    logic               held_live;

    assign masked    = pending & src_en;
    assign held_live = |held_hit;

    // per-source match of the held vector: liveness and hardware clear
    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_match
        assign held_hit[gi] = (irq_vec == VEC_W'(gi + 1)) && masked[gi];
        assign hw_clr[gi]   = take && (irq_vec == VEC_W'(gi + 1));
    end

    irq_flag_bank #(
        .NUM_SRC (NUM_SRC),
        .NUM_LVL (NUM_LVL),
        .ADDR_W  (ADDR_W)
    ) flag_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_set   (src_set),
        .lvl_mode  (lvl_mode),
        .lvl_pin_n (lvl_pin_n),
        .wr_en     (flag_wr),
        .wr_addr   (flag_addr),
        .wr_data   (flag_wdata),
        .hw_clr    (hw_clr),
        .flag_q    (flags),
        .pending   (pending)
    );

    irq_prio_sel #(
        .NUM_SRC (NUM_SRC),
        .VEC_W   (VEC_W)
    ) prio_i (
        .masked  (masked),
        .grant   (grant),
        .any     (any),
        .win_vec (win_vec)
    );

    irq_entry_seq #(
        .VEC_W     (VEC_W),
        .ENTRY_CYC (ENTRY_CYC),
        .RET_CYC   (RET_CYC),
        .SP_W      (SP_W),
        .SP_INIT   (SP_INIT)
    ) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .any         (any),
        .win_vec     (win_vec),
        .held_live   (held_live),
        .insn_busy   (insn_busy),
        .insn_retire (insn_retire),
        .irq_ack     (irq_ack),
        .ret_strobe  (ret_strobe),
        .gie_wr      (gie_wr),
        .gie_wdata   (gie_wdata),
        .req_q       (irq_req),
        .vec_q       (irq_vec),
        .gie_q       (gie),
        .take        (take),
        .busy        (seq_busy),
        .sp_q        (stk_ptr)
    );

    assert_grant_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    assert_req_has_vec_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec != '0));
    assert_ack_clears_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !(|(src_set & hw_clr))) |=> ((flags & $past(hw_clr)) == '0));
endmodule

// File: tb/irq_vector_ctrl_tb_top.sv
// Self-checking bench: behavioural reference model compared every cycle,
// plus directed checks on each requirement.
module irq_vector_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] src_set = '0;
    logic [1:0]  lvl_mode = '0;
    logic [1:0]  lvl_pin_n = 2'b11;
    logic [12:0] src_en = '0;
    logic        flag_wr = 1'b0;
    logic [0:0]  flag_addr = '0;
    logic [7:0]  flag_wdata = '0;
    logic        gie_wr = 1'b0;
    logic        gie_wdata = 1'b0;
    logic        insn_busy = 1'b0;
    logic        insn_retire = 1'b0;
    logic        irq_ack = 1'b0;
    logic        ret_strobe = 1'b0;
    logic        irq_req;
    logic [3:0]  irq_vec;
    logic [12:0] flags;
    logic        gie;
    logic        seq_busy;
    logic [7:0]  stk_ptr;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    irq_vector_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .src_set(src_set), .lvl_mode(lvl_mode),
        .lvl_pin_n(lvl_pin_n), .src_en(src_en), .flag_wr(flag_wr),
        .flag_addr(flag_addr), .flag_wdata(flag_wdata), .gie_wr(gie_wr),
        .gie_wdata(gie_wdata), .insn_busy(insn_busy), .insn_retire(insn_retire),
        .irq_ack(irq_ack), .ret_strobe(ret_strobe), .irq_req(irq_req),
        .irq_vec(irq_vec), .flags(flags), .gie(gie), .seq_busy(seq_busy),
        .stk_ptr(stk_ptr)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit [12:0] m_flag;
    bit        m_gie, m_req, m_hold, m_started;
    int        m_vec, m_state, m_cnt, m_sp;
    bit [12:0] t_msk;
    int        t_win;
    bit        t_take, t_elig, t_live;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_flag = '0; m_gie = 0; m_req = 0; m_hold = 0;
            m_vec = 0; m_state = 0; m_cnt = 0; m_sp = 'hDF; m_started = 1;
        end else begin
            for (int i = 0; i < 13; i++)
                t_msk[i] = ((i < 2 && lvl_mode[i % 2]) ? !lvl_pin_n[i % 2] : m_flag[i]) && src_en[i];
            t_win = 0;
            for (int i = 12; i >= 0; i--) if (t_msk[i]) t_win = i + 1;
            t_live = (m_vec != 0) && t_msk[m_vec - 1];
            t_elig = m_gie && !m_hold && !insn_busy && m_state == 0 && t_win != 0;
            t_take = irq_ack && m_req && m_state == 0;
            for (int i = 0; i < 13; i++) begin
                if (i < 2 && lvl_mode[i % 2]) m_flag[i] = 0;
                else if (src_set[i]) m_flag[i] = 1;
                else if ((flag_wr && int'(flag_addr) == i / 8 && flag_wdata[i % 8]) ||
                         (t_take && m_vec == i + 1)) m_flag[i] = 0;
            end
            if (t_take) m_gie = 0;
            else if (m_state == 2 && m_cnt == 0) m_gie = 1;
            else if (m_state == 0 && gie_wr) m_gie = gie_wdata;
            if (m_state == 2 && m_cnt == 0) m_hold = 1;
            else if (m_state == 0 && insn_retire) m_hold = 0;
            if (t_take) m_req = 0;
            else if (m_req) begin
                if (!t_live || !m_gie_prev() || m_state != 0) m_req = 0;
            end else if (t_elig) begin
                m_req = 1; m_vec = t_win;
            end
            if (m_state == 0) begin
                if (t_take) begin m_state = 1; m_cnt = 3; end
                else if (ret_strobe) begin m_state = 2; m_cnt = 3; end
            end else if (m_cnt == 0) begin
                m_sp = (m_state == 1) ? m_sp - 2 : m_sp + 2;
                m_state = 0;
            end else m_cnt--;
            m_gie_old = m_gie;
        end
    end

    // previous-cycle global enable used by the withdrawal rule
    bit m_gie_old;
    function automatic bit m_gie_prev();
        return m_gie_old_snap;
    endfunction
    bit m_gie_old_snap;
    always @(negedge clk) m_gie_old_snap = m_gie_old;

    // every-cycle comparison of outputs against the model
    always @(negedge clk) begin
        if (m_started) begin
            chk("R2 flags", int'(flags), int'(m_flag));
            chk("R11 gie", int'(gie), int'(m_gie));
            chk("R4 irq_req", int'(irq_req), int'(m_req));
            if (m_req) chk("R5 irq_vec", int'(irq_vec), m_vec);
            chk("R6 seq_busy", int'(seq_busy), int'(m_state != 0));
            chk("R8 stk_ptr", int'(stk_ptr), m_sp);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_src(input int idx);
        src_set[idx] = 1'b1; step(1); src_set[idx] = 1'b0;
    endtask

    task automatic wr_flags(input bit a, input logic [7:0] d);
        flag_wr = 1'b1; flag_addr = a; flag_wdata = d; step(1); flag_wr = 1'b0;
    endtask

    task automatic do_ack();
        irq_ack = 1'b1; step(1); irq_ack = 1'b0;
    endtask

    // return, let it finish, then retire one instruction
    task automatic do_return_retire();
        ret_strobe = 1'b1; step(1); ret_strobe = 1'b0;
        step(4);
        insn_retire = 1'b1; step(1); insn_retire = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_errors++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        step(3);
        // r1_ reset values
        chk("R1 flags", int'(flags), 0);
        chk("R1 gie", int'(gie), 0);
        chk("R1 req", int'(irq_req), 0);
        chk("R1 vec", int'(irq_vec), 0);
        chk("R1 busy", int'(seq_busy), 0);
        chk("R1 sp", int'(stk_ptr), 'hDF);
        rst_n = 1'b1;
        step(2);

        // R2: flags latch while disabled
        src_set = 13'h0220; step(1); src_set = '0;
        step(3);
        chk("R2 latched", int'(flags), 'h220);
        chk("R2 no req", int'(irq_req), 0);

        // R3: zero write ignored, one clears, set wins
        wr_flags(1'b0, 8'h00); step(1);
        chk("R3 zero write", int'(flags), 'h220);
        wr_flags(1'b1, 8'h02); step(1);
        chk("R3 clear bit9", int'(flags), 'h020);
        src_set[5] = 1'b1; flag_wr = 1'b1; flag_addr = 1'b0; flag_wdata = 8'h20;
        step(1); src_set[5] = 1'b0; flag_wr = 1'b0; step(1);
        chk("R3 set wins", int'(flags), 'h020);
        wr_flags(1'b0, 8'h20); step(1);
        chk("R3 clear bit5", int'(flags), 'h000);

        // R11 / R4: enable and resolve priority
        src_en = 13'h1FFF & ~13'h0400;
        gie_wr = 1'b1; gie_wdata = 1'b1; step(1); gie_wr = 1'b0;
        chk("R11 gie set", int'(gie), 1);
        src_set = 13'h0088; step(1); src_set = '0;
        chk("R4 not yet", int'(irq_req), 0);
        step(1);
        chk("R4 req", int'(irq_req), 1);
        chk("R4 lowest wins", int'(irq_vec), 4);

        // R5: higher priority arrives, vector held
        pulse_src(0); step(2);
        chk("R5 vec held", int'(irq_vec), 4);

        // R6: acknowledge and entry
        do_ack();
        chk("R6 req drop", int'(irq_req), 0);
        chk("R6 gie clr", int'(gie), 0);
        chk("R6 flag3 clr", int'(flags), 'h081);
        chk("R6 busy", int'(seq_busy), 1);
        step(3);
        chk("R6 busy 4th", int'(seq_busy), 1);
        step(1);
        chk("R6 idle", int'(seq_busy), 0);
        chk("R6 sp", int'(stk_ptr), 'hDD);

        // R8 / R9: return, hold, retire
        ret_strobe = 1'b1; step(1); ret_strobe = 1'b0;
        chk("R8 busy", int'(seq_busy), 1);
        step(4);
        chk("R8 gie", int'(gie), 1);
        chk("R8 sp", int'(stk_ptr), 'hDF);
        step(3);
        chk("R9 held", int'(irq_req), 0);
        insn_retire = 1'b1; step(1); insn_retire = 1'b0;
        step(2);
        chk("R9 after retire", int'(irq_req), 1);
        chk("R9 vec1", int'(irq_vec), 1);
        do_ack(); step(4);
        do_return_retire(); step(2);
        chk("R4 next vec", int'(irq_vec), 8);
        do_ack(); step(4);
        do_return_retire(); step(2);
        chk("R4 all served", int'(flags), 0);

        // R10: multi-cycle instruction holds off the request
        insn_busy = 1'b1;
        pulse_src(12); step(3);
        chk("R10 blocked", int'(irq_req), 0);
        insn_busy = 1'b0; step(1);
        chk("R10 released", int'(irq_req), 1);
        chk("R10 vec13", int'(irq_vec), 13);
        do_ack(); step(4);
        do_return_retire(); step(2);

        // R2: disabled source latched, taken when enabled
        pulse_src(10); step(3);
        chk("R2 disabled", int'(irq_req), 0);
        src_en[10] = 1'b1; step(2);
        chk("R2 enabled vec", int'(irq_vec), 11);

        // R11: clearing gie withdraws the request
        gie_wr = 1'b1; gie_wdata = 1'b0; step(1); gie_wr = 1'b0; step(1);
        chk("R11 withdrawn", int'(irq_req), 0);
        chk("R11 flag kept", int'(flags), 'h400);
        wr_flags(1'b1, 8'h04);
        gie_wr = 1'b1; gie_wdata = 1'b1; step(1); gie_wr = 1'b0; step(2);

        // R7: level-mode external source 1
        lvl_mode[1] = 1'b1; step(1);
        pulse_src(1); step(2);
        chk("R7 no flag", int'(flags), 0);
        chk("R7 pin high", int'(irq_req), 0);
        lvl_pin_n[1] = 1'b0; step(3);
        chk("R7 level req", int'(irq_req), 1);
        chk("R7 vec2", int'(irq_vec), 2);
        do_ack();
        chk("R7 ack no flag", int'(flags), 0);
        step(4);
        do_return_retire(); step(2);
        chk("R7 still low", int'(irq_req), 1);
        lvl_pin_n[1] = 1'b1; step(2);
        chk("R7 released", int'(irq_req), 0);

        step(3);
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule